// File: doc/BRIEF.md
# Word Aligner Synchronization Controller

This block sits behind a deserializer and turns an unframed stream of 10-bit parallel words into word-aligned code groups. For every valid input word it joins the word with the one before it and looks for a programmable alignment pattern at each of the ten bit offsets. When it is allowed to search and a match is found, the lowest matching offset becomes the word boundary. That boundary is used for every later word until the next permitted realignment. Permission to search comes from an align-enable input. In level mode it is granted for as long as the enable is high. In edge mode it is granted for the first match after each rising edge of the enable. An optional mode also treats the bitwise complement of the pattern as a match.

A hysteresis state machine decides whether the link is synchronized. It has four states: HUNT (no pattern seen), GAIN (counting consecutive patterns), LOCKED (synchronized, error count zero) and DEGRADED (synchronized, error count above zero). The transitions are:
- hunt_to_gain: the first good pattern word arrives.
- gain_to_locked or hunt_to_locked: the programmed number of consecutive good pattern words is reached.
- gain_to_hunt: a non-pattern word or a bad word arrives during counting.
- locked_to_degraded: the first bad word arrives while locked.
- degraded_to_locked: the error count is worked back down to zero.
- locked_to_hunt or degraded_to_hunt: the error count would pass the programmed limit.

The aligned words come out one clock later, together with a pattern-detect flag and the synchronization status.

Top module: `wa_sync_ctrl`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, sync_ok, pat_det and out_valid are 0. The held offset, the pattern count and the error count are cleared to zero.
- R2: Candidate k (k = 0..9) is bits [k+9:k] of {previous valid word, current word}. The current word occupies bits [9:0]. A candidate matches when its low PAT_LEN bits equal cfg_pattern[PAT_LEN-1:0]. When a search is permitted, the lowest matching offset is taken as the boundary and used for the same word.
- R3: On the clock edge that samples a valid word, out_valid goes to 1 and out_data takes the candidate at the boundary in force for that word. Without a permitted match, the boundary is the held offset.
- R4: In level mode (cfg_edge_mode=0), every valid word that has a match while align_en is 1 moves the boundary to its lowest match. While align_en is 0 the offset is held, even if the pattern appears at another offset.
- R5: In edge mode (cfg_edge_mode=1), a rising edge of align_en permits exactly one realignment: the first matching word at or after that edge. Later matches while align_en stays high do not move the offset.
- R6: With cfg_cmpl_en=1, a candidate whose low PAT_LEN bits equal the bitwise complement of the pattern also matches. With cfg_cmpl_en=0 it does not match.
- R7: pat_det is 1 for one output word exactly when the emitted aligned word matches (true form, or complement form when enabled). This holds whether or not that word was flagged bad.
- R8: Synchronization is gained on the good pattern word that completes cfg_lock_pats+1 consecutive good pattern words (1 to 256). A valid non-pattern word, or a pattern word with in_code_err=1, restarts the count. sync_ok rises on the same edge that samples the completing word.
- R9: Each valid word with in_code_err=1 raises the error count while synchronized. The bad word that finds the count already at cfg_err_limit (0 to 7) drops sync_ok on its sampling edge. With a limit of 0, the first bad word drops sync.
- R10: While the error count is above zero, every run of cfg_good_run+1 consecutive good words (1 to 256) lowers it by one. A bad word restarts the run.
- R11: Cycles with in_valid=0 change nothing: sync_ok, out_data, the offset, the stored previous word and all counts keep their values, and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 10 | Raw word from the deserializer |
| in_valid | input | 1 | Word strobe |
| in_code_err | input | 1 | Marks the current word as bad |
| align_en | input | 1 | Pattern-align enable |
| cfg_pattern | input | 10 | Alignment pattern; low PAT_LEN bits used |
| cfg_edge_mode | input | 1 | 1 = edge-triggered realign, 0 = level |
| cfg_cmpl_en | input | 1 | Also accept the complemented pattern |
| cfg_lock_pats | input | 8 | Consecutive patterns for sync, minus one |
| cfg_err_limit | input | 3 | Bad words tolerated before sync is lost |
| cfg_good_run | input | 8 | Good-word run length per decrement, minus one |
| out_data | output | 10 | Aligned word |
| out_valid | output | 1 | out_data carries a new word |
| sync_ok | output | 1 | Synchronization status |
| pat_det | output | 1 | Aligned word matched the pattern |

## Verification
Two functions can land on the same word. The aligner sees a pattern and locks a boundary, while the sync machine sees a bad word. The bench provokes this by sending a word that holds the pattern at the current boundary and also has in_code_err raised. It then checks that out_data and pat_det report the pattern, but sync_ok does not rise. A second collision is also exercised: a rising edge of align_en in edge mode arrives together with a matching word. The bench judges it by the boundary seen in the very next output word.

// File: rtl/wa_pkg.sv
package wa_pkg;

    // Synchronization state machine encoding
    typedef enum logic [1:0] {
        ST_HUNT     = 2'd0,
        ST_GAIN     = 2'd1,
        ST_LOCKED   = 2'd2,
        ST_DEGRADED = 2'd3
    } sync_state_t;

endpackage

// File: rtl/wa_offset_search.sv
// Compares the pattern against every bit offset of the joined window.
module wa_offset_search #(
    parameter int WORD_W  = 10,
    parameter int PAT_LEN = 10,
    localparam int WIN_W  = WORD_W + PAT_LEN - 1
) (
    input  logic [WIN_W-1:0]   window,
    input  logic [PAT_LEN-1:0] pattern,
    input  logic               cmpl_en,
    output logic [WORD_W-1:0]  hit_vec
);

    for (genvar k = 0; k < WORD_W; k++) begin : g_off
        logic [PAT_LEN-1:0] slice;
        logic               true_hit;
        logic               inv_hit;

        assign slice    = window[k +: PAT_LEN];
        assign true_hit = (slice == pattern);
        assign inv_hit  = cmpl_en && (slice == ~pattern);
        assign hit_vec[k] = true_hit || inv_hit;
    end

endmodule

// File: rtl/wa_boundary_lock.sv
// Holds the word boundary, arbitrates realignment and emits aligned words.
module wa_boundary_lock #(
    parameter int WORD_W  = 10,
    parameter int PAT_LEN = 10,
    localparam int OFF_W  = $clog2(WORD_W),
    localparam int JW     = 2 * WORD_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_W-1:0]  in_data,
    input  logic               in_valid,
    input  logic               align_en,
    input  logic               edge_mode,
    input  logic               cmpl_en,
    input  logic [PAT_LEN-1:0] pattern,
    output logic [WORD_W-1:0]  out_data,
    output logic               out_valid,
    output logic               pat_det,
    output logic               word_pat
);

    logic [WORD_W-2:0] prev_q;
    logic [OFF_W-1:0]  held_off;
    logic              pend_q;
    logic              align_q;

    logic [JW-1:0]     joined;
    logic [WORD_W-1:0] hit_vec;
    logic              any_hit;
    logic [OFF_W-1:0]  hit_off;
    logic              rise;
    logic              armed;
    logic              take_new;
    logic [OFF_W-1:0]  eff_off;
    logic [WORD_W-1:0] aligned;
    logic              aligned_hit;

    assign joined = {prev_q, in_data};

    wa_offset_search #(
        .WORD_W  (WORD_W),
        .PAT_LEN (PAT_LEN)
    ) u_search (
        .window  (joined[WORD_W+PAT_LEN-2:0]),
        .pattern (pattern),
        .cmpl_en (cmpl_en),
        .hit_vec (hit_vec)
    );

    // Lowest matching offset wins
    always_comb begin
        any_hit = |hit_vec;
        hit_off = '0;
        for (int k = WORD_W - 1; k >= 0; k--) begin
            if (hit_vec[k]) begin
                hit_off = OFF_W'(k);
            end
        end
    end

    always_comb begin
        rise        = align_en && !align_q;
        armed       = edge_mode ? (pend_q || rise) : align_en;
        take_new    = in_valid && armed && any_hit;
        eff_off     = take_new ? hit_off : held_off;
        aligned     = WORD_W'(joined >> eff_off);
        aligned_hit = hit_vec[eff_off];
        word_pat    = in_valid && aligned_hit;
    end

    // Boundary state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= '0;
            held_off <= '0;
            pend_q   <= 1'b0;
            align_q  <= 1'b0;
        end else begin
            align_q <= align_en;
            if (!edge_mode || take_new) begin
                pend_q <= 1'b0;
            end else if (rise) begin
                pend_q <= 1'b1;
            end
            if (in_valid) begin
                prev_q <= in_data[WORD_W-2:0];
                if (take_new) begin
                    held_off <= hit_off;
                end
            end
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
            pat_det   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            pat_det   <= in_valid && aligned_hit;
            if (in_valid) begin
                out_data <= aligned;
            end
        end
    end

endmodule

// File: rtl/wa_sync_fsm.sv
// Hysteresis machine: pattern count to gain sync, leaky error count to lose it.
module wa_sync_fsm
    import wa_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int ERR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_valid,
    input  logic             word_pat,
    input  logic             word_bad,
    input  logic [CNT_W-1:0] cfg_lock_pats,
    input  logic [ERR_W-1:0] cfg_err_limit,
    input  logic [CNT_W-1:0] cfg_good_run,
    output logic             sync_ok
);

    sync_state_t      st_q, st_nx;
    logic [CNT_W-1:0] pat_q, pat_nx;
    logic [ERR_W-1:0] err_q, err_nx;
    logic [CNT_W-1:0] run_q, run_nx;

    always_comb begin
        st_nx  = st_q;
        pat_nx = pat_q;
        err_nx = err_q;
        run_nx = run_q;
        if (word_valid) begin
            unique case (st_q)
                ST_HUNT, ST_GAIN: begin
                    if (word_pat && !word_bad) begin
                        if (pat_q == cfg_lock_pats) begin
                            st_nx  = ST_LOCKED;
                            pat_nx = '0;
                            err_nx = '0;
                            run_nx = '0;
                        end else begin
                            st_nx  = ST_GAIN;
                            pat_nx = pat_q + CNT_W'(1);
                        end
                    end else begin
                        st_nx  = ST_HUNT;
                        pat_nx = '0;
                    end
                end
                ST_LOCKED: begin
                    if (word_bad) begin
                        run_nx = '0;
                        if (cfg_err_limit == '0) begin
                            st_nx  = ST_HUNT;
                            err_nx = '0;
                        end else begin
                            st_nx  = ST_DEGRADED;
                            err_nx = ERR_W'(1);
                        end
                    end
                end
                ST_DEGRADED: begin
                    if (word_bad) begin
                        run_nx = '0;
                        if (err_q >= cfg_err_limit) begin
                            st_nx  = ST_HUNT;
                            err_nx = '0;
                        end else begin
                            err_nx = err_q + ERR_W'(1);
                        end
                    end else if (run_q == cfg_good_run) begin
                        run_nx = '0;
                        err_nx = err_q - ERR_W'(1);
                        if (err_q == ERR_W'(1)) begin
                            st_nx = ST_LOCKED;
                        end
                    end else begin
                        run_nx = run_q + CNT_W'(1);
                    end
                end
                default: begin
                    st_nx  = ST_HUNT;
                    pat_nx = '0;
                    err_nx = '0;
                    run_nx = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_HUNT;
            pat_q <= '0;
            err_q <= '0;
            run_q <= '0;
        end else begin
            st_q  <= st_nx;
            pat_q <= pat_nx;
            err_q <= err_nx;
            run_q <= run_nx;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_ok <= 1'b0;
        end else begin
            sync_ok <= (st_nx == ST_LOCKED) || (st_nx == ST_DEGRADED);
        end
    end

endmodule

// File: rtl/wa_sync_ctrl.sv
module wa_sync_ctrl #(
    parameter int WORD_W  = 10,
    parameter int PAT_LEN = 10,
    parameter int CNT_W   = 8,
    parameter int ERR_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_code_err,
    input  logic              align_en,
    input  logic [WORD_W-1:0] cfg_pattern,
    input  logic              cfg_edge_mode,
    input  logic              cfg_cmpl_en,
    input  logic [CNT_W-1:0]  cfg_lock_pats,
    input  logic [ERR_W-1:0]  cfg_err_limit,
    input  logic [CNT_W-1:0]  cfg_good_run,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid,
    output logic              sync_ok,
    output logic              pat_det
);

    logic word_pat;

    wa_boundary_lock #(
        .WORD_W  (WORD_W),
        .PAT_LEN (PAT_LEN)
    ) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .align_en  (align_en),
        .edge_mode (cfg_edge_mode),
        .cmpl_en   (cfg_cmpl_en),
        .pattern   (cfg_pattern[PAT_LEN-1:0]),
        .out_data  (out_data),
        .out_valid (out_valid),
        .pat_det   (pat_det),
        .word_pat  (word_pat)
    );

    wa_sync_fsm #(
        .CNT_W (CNT_W),
        .ERR_W (ERR_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .word_valid    (in_valid),
        .word_pat      (word_pat),
        .word_bad      (in_code_err),
        .cfg_lock_pats (cfg_lock_pats),
        .cfg_err_limit (cfg_err_limit),
        .cfg_good_run  (cfg_good_run),
        .sync_ok       (sync_ok)
    );

endmodule

// File: rtl/wa_sync_ctrl_chk.sv
module wa_sync_ctrl_chk #(
    parameter int WORD_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_code_err,
    input logic [WORD_W-1:0] out_data,
    input logic              out_valid,
    input logic              sync_ok,
    input logic              pat_det
);

    // Sync is only gained on a good sampled word
    assert_gain_on_good_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_ok) |-> $past(in_valid && !in_code_err));

    // Sync is only lost on a bad sampled word
    assert_loss_on_bad_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_ok) |-> $past(in_valid && in_code_err));

    assert_out_follows_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_no_output_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(sync_ok) && $stable(out_data)));

    assert_detect_with_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pat_det |-> out_valid);

endmodule

bind wa_sync_ctrl wa_sync_ctrl_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_code_err (in_code_err),
    .out_data    (out_data),
    .out_valid   (out_valid),
    .sync_ok     (sync_ok),
    .pat_det     (pat_det)
);

// File: tb/test_wa_sync_ctrl.sv
`timescale 1ns/1ps
module test_wa_sync_ctrl;

    localparam logic [9:0] PAT  = 10'h17C;
    localparam logic [9:0] NPAT = 10'h283;   // ~PAT
    localparam logic [9:0] WOFF = 10'h3E2;   // PAT sits at offset 3 of {WOFF,WOFF}
    localparam logic [9:0] DAT  = 10'h000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_code_err = 1'b0;
    logic       align_en = 1'b0;
    logic [9:0] cfg_pattern = PAT;
    logic       cfg_edge_mode = 1'b0;
    logic       cfg_cmpl_en = 1'b0;
    logic [7:0] cfg_lock_pats = 8'd0;
    logic [2:0] cfg_err_limit = 3'd0;
    logic [7:0] cfg_good_run = 8'd0;
    logic [9:0] out_data;
    logic       out_valid;
    logic       sync_ok;
    logic       pat_det;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    wa_sync_ctrl i_wa_sync_ctrl (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_code_err(in_code_err), .align_en(align_en), .cfg_pattern(cfg_pattern),
        .cfg_edge_mode(cfg_edge_mode), .cfg_cmpl_en(cfg_cmpl_en),
        .cfg_lock_pats(cfg_lock_pats), .cfg_err_limit(cfg_err_limit),
        .cfg_good_run(cfg_good_run), .out_data(out_data), .out_valid(out_valid),
        .sync_ok(sync_ok), .pat_det(pat_det)
    );

    function automatic logic [9:0] cand(input logic [9:0] p, input logic [9:0] c, input int k);
        logic [19:0] j;
        j = {p, c};
        return j[k +: 10];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        in_valid = 0; in_code_err = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic send(input logic [9:0] d, input logic err);
        in_data = d; in_valid = 1; in_code_err = err;
        @(negedge clk);
        in_valid = 0; in_code_err = 0;
    endtask

    task automatic t_reset();
        cfg_edge_mode = 0; align_en = 1;
        rst_n = 0;
        repeat (2) @(negedge clk);
        chk("R1 sync_ok in reset", sync_ok, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 sync_ok", sync_ok, 0);
        chk("R1 pat_det", pat_det, 0);
        chk("R1 out_valid", out_valid, 0);
    endtask

    task automatic t_search();
        cfg_edge_mode = 0; cfg_cmpl_en = 0; cfg_lock_pats = 8'd200; align_en = 1;
        do_reset();
        send(10'h002, 0);
        chk("R7 no match", pat_det, 0);
        send(10'h3E0, 0);
        chk("R2 offset3 data", out_data, PAT);
        chk("R7 detect", pat_det, 1);
        chk("R3 out_valid", out_valid, 1);
        send(WOFF, 0);
        chk("R3 held offset data", out_data, cand(10'h3E0, WOFF, 3));
        chk("R7 no detect", pat_det, 0);
        send(WOFF, 0);
        chk("R2 offset3 again", out_data, PAT);
        chk("R7 detect again", pat_det, 1);
        // level hold and realign
        align_en = 0;
        send(PAT, 0);
        chk("R4 hold while low", out_data, cand(WOFF, PAT, 3));
        chk("R4 no detect", pat_det, 0);
        align_en = 1;
        send(PAT, 0);
        chk("R4 realign to 0", out_data, PAT);
        chk("R4 detect", pat_det, 1);
    endtask

    task automatic t_edge();
        cfg_edge_mode = 1; cfg_cmpl_en = 0; cfg_lock_pats = 8'd200; align_en = 0;
        do_reset();
        send(WOFF, 0);
        send(WOFF, 0);
        chk("R5 no search before edge", out_data, WOFF);
        align_en = 1;
        send(WOFF, 0);
        chk("R5 realign on edge", out_data, PAT);
        chk("R5 detect on edge", pat_det, 1);
        send(PAT, 0);
        chk("R5 no second realign", out_data, cand(WOFF, PAT, 3));
        send(PAT, 0);
        chk("R5 offset held", out_data, cand(PAT, PAT, 3));
        align_en = 0;
        send(PAT, 0);
        align_en = 1;
        send(PAT, 0);
        chk("R5 new edge realigns", out_data, PAT);
        chk("R5 detect", pat_det, 1);
    endtask

    task automatic t_cmpl();
        cfg_edge_mode = 0; cfg_cmpl_en = 0; cfg_lock_pats = 8'd0; align_en = 1;
        do_reset();
        send(NPAT, 0);
        send(NPAT, 0);
        chk("R6 complement rejected", pat_det, 0);
        chk("R6 no sync", sync_ok, 0);
        cfg_cmpl_en = 1;
        send(NPAT, 0);
        chk("R6 complement accepted", pat_det, 1);
        chk("R6 data", out_data, NPAT);
        chk("R6 sync from complement", sync_ok, 1);
        cfg_cmpl_en = 0;
    endtask

    task automatic t_gain();
        cfg_edge_mode = 0; cfg_lock_pats = 8'd2; align_en = 1;
        do_reset();
        send(PAT, 0);
        send(PAT, 0);
        chk("R8 two of three", sync_ok, 0);
        send(DAT, 0);
        chk("R8 data restarts", sync_ok, 0);
        send(PAT, 0);
        send(PAT, 0);
        chk("R8 restart count", sync_ok, 0);
        send(PAT, 0);
        chk("R8 third pattern", sync_ok, 1);
        // pattern flagged bad does not count
        cfg_lock_pats = 8'd0;
        do_reset();
        send(PAT, 1);
        chk("R8 bad pattern no sync", sync_ok, 0);
        chk("R7 bad pattern still detected", pat_det, 1);
        chk("R3 bad pattern data", out_data, PAT);
        send(PAT, 0);
        chk("R8 single pattern sync", sync_ok, 1);
    endtask

    task automatic t_loss();
        cfg_lock_pats = 8'd0; cfg_err_limit = 3'd2; cfg_good_run = 8'd0; align_en = 1;
        do_reset();
        send(PAT, 0);
        send(DAT, 1);
        send(DAT, 1);
        chk("R9 two bad tolerated", sync_ok, 1);
        send(DAT, 1);
        chk("R9 third bad loses", sync_ok, 0);
        cfg_err_limit = 3'd0;
        do_reset();
        send(PAT, 0);
        chk("R9 locked", sync_ok, 1);
        send(DAT, 1);
        chk("R9 limit zero", sync_ok, 0);
    endtask

    task automatic t_recover();
        cfg_lock_pats = 8'd0; cfg_err_limit = 3'd2; cfg_good_run = 8'd1; align_en = 1;
        do_reset();
        send(PAT, 0);
        send(DAT, 1); send(DAT, 1);
        send(DAT, 0);
        send(DAT, 1);
        chk("R10 short run no decrement", sync_ok, 0);
        do_reset();
        send(PAT, 0);
        send(DAT, 1); send(DAT, 1);
        send(DAT, 0); send(DAT, 0);
        send(DAT, 1);
        chk("R10 one decrement", sync_ok, 1);
        send(DAT, 1);
        chk("R10 loss after decrement", sync_ok, 0);
        do_reset();
        send(PAT, 0);
        send(DAT, 1); send(DAT, 1);
        for (int i = 0; i < 4; i++) send(DAT, 0);
        send(DAT, 1); send(DAT, 1);
        chk("R10 fully recovered", sync_ok, 1);
        send(DAT, 1);
        chk("R10 loss after recovery", sync_ok, 0);
    endtask

    task automatic t_idle();
        cfg_lock_pats = 8'd0; cfg_err_limit = 3'd0; align_en = 1;
        do_reset();
        send(PAT, 0);
        in_data = WOFF; in_code_err = 1; in_valid = 0;
        repeat (3) @(negedge clk);
        chk("R11 sync kept", sync_ok, 1);
        chk("R11 no output", out_valid, 0);
        chk("R11 data held", out_data, PAT);
        in_code_err = 0;
        send(PAT, 0);
        chk("R11 prev word unchanged", out_data, PAT);
        chk("R11 sync still", sync_ok, 1);
    endtask

    initial begin
        t_reset();
        t_search();
        t_edge();
        t_cmpl();
        t_gain();
        t_loss();
        t_recover();
        t_idle();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule